// File: doc/BRIEF.md
# Saturating Clear-on-Read Line Statistics Counters

This block keeps two statistics counters for the receive side of a 10/100 Ethernet physical layer. The first one counts false-carrier events in 8 bits. The second counts receive symbol errors in 16 bits. It counts an error only while the receive-data-valid qualifier is high and the loopback flag is low. Neither counter wraps: each one stops at its all-ones value. When a counter moves from just below its half-full point to the half-full point, the block sends a one-cycle interrupt event to the interrupt logic.

Management software reads the counters through a synchronous register read port with one cycle of latency. A read returns the current count and clears that counter to zero. If an event lands in the cycle of the read, the read still returns the old value, and the counter starts again at one, so the event is not lost. The MDIO frame logic and the symbol decoder that produce the event strobes sit outside this block.

Top module: `phy_err_stats`

## Requirements
- R1: After reset, both counters are zero, `rd_data_o` is 0x0000, and both interrupt outputs are low.
- R2: Each clock cycle with `fc_evt_i` high adds exactly one to the false-carrier count.
- R3: The false-carrier count stops at 0xFF. Further events leave it at 0xFF until it is read.
- R4: `fc_half_irq_o` is high for exactly one cycle when the false-carrier count goes from 0x7F to 0x80. That cycle is the one after the clock edge that samples the event. The output stays low at every other count, including counts above 0x80.
- R5: A cycle with `rx_err_i` high adds one to the receive-error count only if `rx_dv_i` is 1 and `loopback_i` is 0 in that same cycle. In any other case the count does not change.
- R6: The receive-error count stops at 0xFFFF.
- R7: `rx_half_irq_o` is high for exactly one cycle when the receive-error count goes from 0x7FFF to 0x8000. That cycle is the one after the clock edge that samples the event.
- R8: A cycle with `rd_en_i` high and `rd_addr_i` = 0x14 puts {8'h00, false-carrier count} on `rd_data_o` one cycle later. Address 0x15 returns the receive-error count the same way. Any other address returns 0x0000. `rd_data_o` keeps its value in cycles with no read.
- R9: A read returns the count as it was before the read, and then clears that counter to zero. The other counter is not affected.
- R10: If a counted event happens in the same cycle as a read of its counter, the read returns the old count and the counter holds 1 afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fc_evt_i | input | 1 | False-carrier event strobe, one event per high cycle |
| rx_err_i | input | 1 | Receive symbol error strobe |
| rx_dv_i | input | 1 | Receive-data-valid qualifier for error counting |
| loopback_i | input | 1 | Loopback mode active; blocks error counting |
| rd_en_i | input | 1 | Register read strobe |
| rd_addr_i | input | 5 | Register read address |
| rd_data_o | output | 16 | Read data, valid the cycle after the strobe |
| fc_half_irq_o | output | 1 | False-carrier half-full event pulse |
| rx_half_irq_o | output | 1 | Receive-error half-full event pulse |

## Verification
The two functions that can fall in the same cycle are the clear done by a read and an increment from an event strobe. The bench raises the read strobe and the event strobe on the same falling edge for both counters. It expects the old count on the read data one cycle later, and a value of one on a second read. The interrupt edge is judged to the exact cycle: a monitor counts every interrupt pulse, and a long saturating run must leave exactly one pulse per counter.

// File: rtl/phy_stat_pkg.sv
package phy_stat_pkg;
    parameter int ADDR_W = 5;
    parameter int DATA_W = 16;
    parameter int FC_W   = 8;
    parameter int RX_W   = 16;

    parameter logic [ADDR_W-1:0] FC_ADDR = 5'h14;
    parameter logic [ADDR_W-1:0] RX_ADDR = 5'h15;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_FC   = 2'd1,
        SEL_RX   = 2'd2
    } rd_sel_e;
endpackage

// File: rtl/sat_cor_counter.sv
module sat_cor_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc_i,
    input  logic         clr_i,
    output logic [W-1:0] cnt_o,
    output logic         half_o
);
    localparam logic [W-1:0] MAX_V   = {W{1'b1}};
    localparam logic [W-1:0] HALF_M1 = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] ONE_V   = {{(W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [W-1:0] cnt;
        logic         half;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.half = 1'b0;
        if (clr_i) begin
            st_d.cnt = inc_i ? ONE_V : '0;
        end else if (inc_i && (st_q.cnt != MAX_V)) begin
            st_d.cnt  = st_q.cnt + ONE_V;
            st_d.half = (st_q.cnt == HALF_M1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o  = st_q.cnt;
    assign half_o = st_q.half;
endmodule

// File: rtl/stat_read_port.sv
module stat_read_port
    import phy_stat_pkg::*;
#(
    parameter int A_W = ADDR_W,
    parameter int D_W = DATA_W,
    parameter int F_W = FC_W,
    parameter int R_W = RX_W,
    parameter logic [A_W-1:0] F_ADDR = FC_ADDR,
    parameter logic [A_W-1:0] R_ADDR = RX_ADDR
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           rd_en_i,
    input  logic [A_W-1:0] rd_addr_i,
    input  logic [F_W-1:0] fc_cnt_i,
    input  logic [R_W-1:0] rx_cnt_i,
    output logic           fc_clr_o,
    output logic           rx_clr_o,
    output logic [D_W-1:0] rd_data_o
);
    typedef struct packed {
        logic [D_W-1:0] data;
    } rd_st_t;

    rd_st_t  st_d, st_q;
    rd_sel_e sel;

    always_comb begin
        sel = SEL_NONE;
        if (rd_en_i) begin
            if (rd_addr_i == F_ADDR)      sel = SEL_FC;
            else if (rd_addr_i == R_ADDR) sel = SEL_RX;
        end
    end

    always_comb begin
        st_d = st_q;
        if (rd_en_i) begin
            st_d.data = '0;
            unique case (sel)
                SEL_FC:  st_d.data[F_W-1:0] = fc_cnt_i;
                SEL_RX:  st_d.data[R_W-1:0] = rx_cnt_i;
                default: st_d.data = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign fc_clr_o  = (sel == SEL_FC);
    assign rx_clr_o  = (sel == SEL_RX);
    assign rd_data_o = st_q.data;
endmodule

// File: rtl/phy_err_stats.sv
module phy_err_stats
    import phy_stat_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fc_evt_i,
    input  logic              rx_err_i,
    input  logic              rx_dv_i,
    input  logic              loopback_i,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              fc_half_irq_o,
    output logic              rx_half_irq_o
);
    logic [FC_W-1:0] fc_cnt;
    logic [RX_W-1:0] rx_cnt;
    logic            fc_clr, rx_clr;
    logic            fc_inc, rx_inc;

    assign fc_inc = fc_evt_i;
    assign rx_inc = rx_err_i && rx_dv_i && !loopback_i;

    sat_cor_counter #(.W(FC_W)) u_fc_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .inc_i  (fc_inc),
        .clr_i  (fc_clr),
        .cnt_o  (fc_cnt),
        .half_o (fc_half_irq_o)
    );

    sat_cor_counter #(.W(RX_W)) u_rx_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .inc_i  (rx_inc),
        .clr_i  (rx_clr),
        .cnt_o  (rx_cnt),
        .half_o (rx_half_irq_o)
    );

    stat_read_port u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_en_i   (rd_en_i),
        .rd_addr_i (rd_addr_i),
        .fc_cnt_i  (fc_cnt),
        .rx_cnt_i  (rx_cnt),
        .fc_clr_o  (fc_clr),
        .rx_clr_o  (rx_clr),
        .rd_data_o (rd_data_o)
    );
endmodule

// File: rtl/phy_err_stats_chk.sv
module phy_err_stats_chk
    import phy_stat_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              fc_evt_i,
    input logic              rx_dv_i,
    input logic              loopback_i,
    input logic              rd_en_i,
    input logic [ADDR_W-1:0] rd_addr_i,
    input logic [DATA_W-1:0] rd_data_o,
    input logic              fc_half_irq_o,
    input logic              rx_half_irq_o,
    input logic [FC_W-1:0]   fc_cnt,
    input logic [RX_W-1:0]   rx_cnt,
    input logic              fc_clr,
    input logic              rx_clr
);
    AST_FC_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (fc_cnt == {FC_W{1'b1}} && !fc_clr) |=> fc_cnt == {FC_W{1'b1}}); // R3
    AST_RX_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_cnt == {RX_W{1'b1}} && !rx_clr) |=> rx_cnt == {RX_W{1'b1}}); // R6
    AST_FC_IRQ_AT_HALF: assert property (@(posedge clk) disable iff (!rst_n)
        fc_half_irq_o |-> (fc_cnt == {1'b1, {(FC_W-1){1'b0}}})); // R4
    AST_FC_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        fc_half_irq_o |=> !fc_half_irq_o); // R4
    AST_RX_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_half_irq_o |=> !rx_half_irq_o); // R7
    AST_RX_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        ((!rx_dv_i || loopback_i) && !rx_clr) |=> $stable(rx_cnt)); // R5
    AST_FC_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && rd_addr_i == FC_ADDR) |=> rd_data_o[DATA_W-1:FC_W] == '0); // R8
    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en_i |=> $stable(rd_data_o)); // R8
    AST_FC_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && rd_addr_i == FC_ADDR && !fc_evt_i) |=> fc_cnt == '0); // R9
    AST_FC_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && rd_addr_i == FC_ADDR && fc_evt_i) |=> fc_cnt == {{(FC_W-1){1'b0}}, 1'b1}); // R10
endmodule

bind phy_err_stats phy_err_stats_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .fc_evt_i      (fc_evt_i),
    .rx_dv_i       (rx_dv_i),
    .loopback_i    (loopback_i),
    .rd_en_i       (rd_en_i),
    .rd_addr_i     (rd_addr_i),
    .rd_data_o     (rd_data_o),
    .fc_half_irq_o (fc_half_irq_o),
    .rx_half_irq_o (rx_half_irq_o),
    .fc_cnt        (fc_cnt),
    .rx_cnt        (rx_cnt),
    .fc_clr        (fc_clr),
    .rx_clr        (rx_clr)
);

// File: tb/sim_phy_err_stats.sv
module sim_phy_err_stats;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fc_evt = 1'b0, rx_err = 1'b0, rx_dv = 1'b0, lb = 1'b0;
    logic        rd_en = 1'b0;
    logic [4:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic        fc_irq, rx_irq;

    int total = 0;
    int bad = 0;
    int fc_irq_n = 0;
    int rx_irq_n = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    phy_err_stats u0 (
        .clk (clk), .rst_n (rst_n), .fc_evt_i (fc_evt), .rx_err_i (rx_err),
        .rx_dv_i (rx_dv), .loopback_i (lb), .rd_en_i (rd_en), .rd_addr_i (rd_addr),
        .rd_data_o (rd_data), .fc_half_irq_o (fc_irq), .rx_half_irq_o (rx_irq)
    );

    always @(negedge clk) begin
        if (rst_n && fc_irq) fc_irq_n++;
        if (rst_n && rx_irq) rx_irq_n++;
    end

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_read(input logic [4:0] a, output logic [15:0] d);
        rd_en = 1'b1; rd_addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    task automatic fc_burst(input int n);
        fc_evt = 1'b1;
        repeat (n) @(negedge clk);
        fc_evt = 1'b0;
    endtask

    task automatic rx_burst(input int n);
        rx_err = 1'b1;
        repeat (n) @(negedge clk);
        rx_err = 1'b0;
    endtask

    task automatic t_reset();
        logic [15:0] d;
        check("R1 rd_data", int'(rd_data), 0);
        check("R1 fc_irq", int'(fc_irq), 0);
        check("R1 rx_irq", int'(rx_irq), 0);
        do_read(5'h14, d); check("R1 fc count", int'(d), 0);
        do_read(5'h15, d); check("R1 rx count", int'(d), 0);
    endtask

    task automatic t_fc_count();
        logic [15:0] d;
        fc_burst(3);
        @(negedge clk);
        fc_burst(2);
        do_read(5'h14, d); check("R2 fc count 5", int'(d), 5);
        do_read(5'h14, d); check("R9 fc cleared", int'(d), 0);
    endtask

    task automatic t_fc_half_sat();
        logic [15:0] d;
        fc_irq_n = 0;
        fc_burst(127);
        check("R4 no irq below half", fc_irq_n, 0);
        fc_evt = 1'b1;
        @(negedge clk);
        fc_evt = 1'b0;
        check("R4 irq cycle", int'(fc_irq), 1);
        @(negedge clk);
        check("R4 irq one cycle", int'(fc_irq), 0);
        fc_burst(200);
        check("R4 single irq total", fc_irq_n, 1);
        do_read(5'h14, d); check("R3 fc saturated", int'(d), 'hFF);
    endtask

    task automatic t_rx_gate();
        logic [15:0] d;
        rx_dv = 1'b0; lb = 1'b0; rx_burst(4);
        rx_dv = 1'b1; lb = 1'b1; rx_burst(4);
        rx_dv = 1'b0; lb = 1'b1; rx_burst(2);
        rx_dv = 1'b1; lb = 1'b0; rx_burst(3);
        fc_burst(2);
        do_read(5'h15, d); check("R5 rx gated count", int'(d), 3);
        do_read(5'h14, d); check("R9 fc untouched by rx read", int'(d), 2);
    endtask

    task automatic t_collide();
        logic [15:0] d;
        fc_burst(4);
        rd_en = 1'b1; rd_addr = 5'h14; fc_evt = 1'b1;
        @(negedge clk);
        rd_en = 1'b0; fc_evt = 1'b0;
        check("R10 fc old value", int'(rd_data), 4);
        do_read(5'h14, d); check("R10 fc restart 1", int'(d), 1);
        rx_burst(6);
        rd_en = 1'b1; rd_addr = 5'h15; rx_err = 1'b1;
        @(negedge clk);
        rd_en = 1'b0; rx_err = 1'b0;
        check("R10 rx old value", int'(rd_data), 6);
        do_read(5'h15, d); check("R10 rx restart 1", int'(d), 1);
    endtask

    task automatic t_addr_hold();
        logic [15:0] d;
        fc_burst(9);
        do_read(5'h16, d); check("R8 other address zero", int'(d), 0);
        do_read(5'h14, d); check("R8 fc read", int'(d), 9);
        fc_burst(3);
        repeat (3) @(negedge clk);
        check("R8 rd_data held", int'(rd_data), 9);
    endtask

    task automatic t_rx_half_sat();
        logic [15:0] d;
        rx_irq_n = 0;
        rx_dv = 1'b1; lb = 1'b0;
        rx_burst(32767);
        check("R7 no irq below half", rx_irq_n, 0);
        rx_err = 1'b1;
        @(negedge clk);
        rx_err = 1'b0;
        check("R7 irq cycle", int'(rx_irq), 1);
        @(negedge clk);
        check("R7 irq one cycle", int'(rx_irq), 0);
        rx_burst(33000);
        check("R7 single irq total", rx_irq_n, 1);
        do_read(5'h15, d); check("R6 rx saturated", int'(d), 'hFFFF);
        do_read(5'h15, d); check("R9 rx cleared", int'(d), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_fc_count();
        t_fc_half_sat();
        t_rx_gate();
        t_collide();
        t_addr_hold();
        t_rx_half_sat();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule